// File: doc/BRIEF.md
# Enveloped Audio Voice

One synthesis voice that emits a signed 16-bit sample on every pulse of a sample-rate tick. A phase accumulator, stepped by a programmable increment on each tick, drives one of six waveform sources: square, sawtooth, triangle, sine, pseudo-random noise, or custom samples streamed from an external buffer. The chosen waveform is then scaled by an attack/decay/sustain/release envelope and by a volume setting. The result is saturated to 16 bits.

A `play` strobe restarts the note. A `key_off` strobe lets the note fade out. A `stop` strobe silences the voice at once. In custom mode the voice walks a sample buffer whose last index is `pcm_last`. It fetches each sample over a valid/ready request channel and supports play-once, loop and ping-pong traversal. The voice holds `req_valid` and `req_index` steady until the source raises `req_ready`, and it takes `req_data` in that same cycle. While a request is still open, a tick does not move the buffer position, so a slow source stretches samples rather than losing them. The voice withdraws an open request only when `stop` or `play` arrives. Control pins are plain strobes, with priority stop over play over tick.

Top module: `snd_voice`

## Requirements
- R1: While reset is asserted, out_sample is 0, out_valid is 0 and req_valid is 0.
- R2: out_valid is high for exactly the cycle after a tick that arrived with neither stop nor play. In that cycle out_sample carries the sample computed from the phase, envelope level and held custom sample as they stood before the tick; the tick then advances them.
- R3: With h the top 16 phase bits, wave_sel 0 (square) gives +32767 when h[15] is 0 and -32767 otherwise. Wave_sel 1 (sawtooth) gives h-32768. Wave_sel 2 (triangle) takes u = h[14:0], inverted when h[15] is 1, and gives 2u-32768.
- R4: Wave_sel 3 (sine) indexes a 64-entry quarter table, entry i = floor(32767*m*(256-m)/16384) with m = 2i+1. The index is h[13:8], inverted when h[14] is 1, and the value is negated when h[15] is 1.
- R5: Wave_sel 4 (noise) outputs a 16-bit right-shifting LFSR read as signed. The LFSR is seeded with 0xACE1 on play and steps on every phase-accumulator carry: shift right, then XOR 0xB400 if the bit shifted out was 1.
- R6: env_word holds attack in [15:12], decay in [11:8], sustain in [7:4] and release in [3:0]. Play sets the level to 0 and enters attack. Each attack tick adds 16*(A+1), clamping at 255, and then moves to decay.
- R7: Each decay tick subtracts D+1. When the level would reach 17*S or less, it is set to 17*S and held there as sustain.
- R8: key_off during attack, decay or sustain enters release. Each release tick subtracts R+1 and clamps at 0, which ends the note so that later samples are 0.
- R9: stop forces out_sample and the envelope level to 0 and withdraws any open sample request by the next cycle. In that cycle it overrides play and tick, and no out_valid pulse follows.
- R10: out_sample = saturate16((wave * level * volume) >>> 14), with an arithmetic (flooring) shift.
- R11: In wave_sel 5, play requests index 0, and each tick of a sounding note requests the next index. A request holds req_valid and req_index stable until req_ready is high, and req_data is taken in that cycle. A tick that arrives while a request is open does not move the index.
- R12: pcm_mode 0 (once) steps the index up to pcm_last. The next step issues no request and zeroes the held sample, so later custom samples are 0.
- R13: pcm_mode 1 (loop) steps from pcm_last back to index 0.
- R14: pcm_mode 2 (ping-pong) reverses direction at pcm_last and at 0 without repeating the end index, giving 0,1,2,3,2,1,0,1 for pcm_last 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Sample-rate strobe |
| wave_sel | input | 3 | Waveform source select |
| phase_inc | input | PHASE_W | Phase increment per tick |
| env_word | input | 16 | Packed attack/decay/sustain/release nibbles |
| volume | input | VOL_W | Unsigned volume |
| pcm_mode | input | 2 | Custom buffer traversal: 0 once, 1 loop, 2 ping-pong |
| pcm_last | input | IDX_W | Last valid buffer index |
| play | input | 1 | Note start strobe |
| key_off | input | 1 | Note release strobe |
| stop | input | 1 | Immediate silence strobe |
| req_valid | output | 1 | Sample request pending |
| req_ready | input | 1 | Source accepts request and presents data |
| req_index | output | IDX_W | Requested buffer index |
| req_data | input | 16 | Signed sample returned with req_ready |
| out_valid | output | 1 | Output sample strobe |
| out_sample | output | 16 | Signed output sample |

## Verification
The critical collision is stop landing in the same cycle as a tick, after the envelope has reached full level, while a sample would otherwise be produced and a fetch may be open. The bench drives both strobes together on one edge. It judges stop the winner if the next cycle shows no out_valid pulse, a zero sample and no request, and if a following tick still yields 0. A second overlap, a tick arriving while a custom-sample request is back-pressured, is provoked by holding req_ready low across a tick. It passes if the index stays put and the buffer walk then resumes unchanged.

// File: rtl/snd_voice_pkg.sv
package snd_voice_pkg;

  localparam int SMP_W   = 16;
  localparam int LEVEL_W = 8;
  localparam int NOISE_W = 16;
  localparam logic [NOISE_W-1:0] NOISE_SEED = 16'hACE1;
  localparam logic [NOISE_W-1:0] NOISE_TAPS = 16'hB400;

  typedef enum logic [2:0] {
    WV_SQUARE = 3'd0,
    WV_SAW    = 3'd1,
    WV_TRI    = 3'd2,
    WV_SINE   = 3'd3,
    WV_NOISE  = 3'd4,
    WV_PCM    = 3'd5
  } wave_e;

  typedef enum logic [2:0] {
    EG_IDLE,
    EG_ATTACK,
    EG_DECAY,
    EG_SUSTAIN,
    EG_RELEASE
  } eg_state_e;

  typedef enum logic [1:0] {
    PM_ONCE     = 2'd0,
    PM_LOOP     = 2'd1,
    PM_PINGPONG = 2'd2
  } pcm_mode_e;

endpackage

// File: rtl/snd_phase_gen.sv
module snd_phase_gen
  import snd_voice_pkg::*;
#(
  parameter int PHASE_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic               advance,
  input  logic [PHASE_W-1:0] inc,
  output logic [15:0]        phase_top,
  output logic [NOISE_W-1:0] noise
);

  logic [PHASE_W-1:0] phase;
  logic [PHASE_W:0]   sum;
  logic [NOISE_W-1:0] noise_next;

  assign sum       = {1'b0, phase} + {1'b0, inc};
  assign phase_top = phase[PHASE_W-1 -: 16];

  always_comb begin
    noise_next = noise >> 1;
    if (noise[0]) noise_next = noise_next ^ NOISE_TAPS;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      phase <= '0;
      noise <= NOISE_SEED;
    end else if (advance) begin
      phase <= sum[PHASE_W-1:0];
      if (sum[PHASE_W]) noise <= noise_next;
    end
  end

endmodule

// File: rtl/snd_wave_gen.sv
module snd_wave_gen
  import snd_voice_pkg::*;
(
  input  wave_e                    sel,
  input  logic [15:0]              h,
  input  logic [NOISE_W-1:0]       noise,
  input  logic signed [SMP_W-1:0]  pcm,
  output logic signed [SMP_W-1:0]  wave
);

  localparam int QDEPTH = 64;

  function automatic logic [15:0] qmag(input logic [5:0] i);
    logic [31:0] m;
    logic [31:0] p;
    m = 32'({i, 1'b1});
    p = 32'd32767 * (m * (32'd256 - m));
    return 16'(p >> 14);
  endfunction

  logic [15:0] qtab [QDEPTH];
  for (genvar g = 0; g < QDEPTH; g++) begin : g_qtab
    assign qtab[g] = qmag(6'(g));
  end

  logic [14:0] tri_u;
  logic [5:0]  sin_idx;
  logic [15:0] sin_mag;

  assign tri_u   = h[15] ? ~h[14:0] : h[14:0];
  assign sin_idx = h[14] ? ~h[13:8] : h[13:8];
  assign sin_mag = qtab[sin_idx];

  always_comb begin
    case (sel)
      WV_SQUARE: wave = h[15] ? 16'sh8001 : 16'sh7FFF;
      WV_SAW:    wave = {~h[15], h[14:0]};
      WV_TRI:    wave = {~tri_u[14], tri_u[13:0], 1'b0};
      WV_SINE:   wave = h[15] ? -$signed(sin_mag) : $signed(sin_mag);
      WV_NOISE:  wave = $signed(noise);
      WV_PCM:    wave = pcm;
      default:   wave = '0;
    endcase
  end

endmodule

// File: rtl/snd_adsr.sv
module snd_adsr
  import snd_voice_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               kill,
  input  logic               key_off,
  input  logic               advance,
  input  logic [15:0]        env_word,
  output logic [LEVEL_W-1:0] level,
  output eg_state_e          state
);

  logic [3:0] a_f, d_f, s_f, r_f;
  logic [7:0] sus;
  logic [4:0] dstep, rstep;
  logic [9:0] up;

  assign a_f   = env_word[15:12];
  assign d_f   = env_word[11:8];
  assign s_f   = env_word[7:4];
  assign r_f   = env_word[3:0];
  assign sus   = {s_f, s_f};
  assign dstep = {1'b0, d_f} + 5'd1;
  assign rstep = {1'b0, r_f} + 5'd1;
  assign up    = {2'b0, level} + {1'b0, ({1'b0, a_f} + 5'd1), 4'b0};

  always_ff @(posedge clk) begin
    if (!rst_n || kill) begin
      state <= EG_IDLE;
      level <= '0;
    end else if (start) begin
      state <= EG_ATTACK;
      level <= '0;
    end else if (key_off && (state == EG_ATTACK || state == EG_DECAY ||
                             state == EG_SUSTAIN)) begin
      state <= EG_RELEASE;
    end else if (advance) begin
      case (state)
        EG_ATTACK: begin
          if (up >= 10'd255) begin
            level <= 8'd255;
            state <= EG_DECAY;
          end else begin
            level <= up[7:0];
          end
        end
        EG_DECAY: begin
          if ({2'b0, level} <= {2'b0, sus} + {5'b0, dstep}) begin
            level <= sus;
            state <= EG_SUSTAIN;
          end else begin
            level <= level - {3'b0, dstep};
          end
        end
        EG_RELEASE: begin
          if (level <= {3'b0, rstep}) begin
            level <= '0;
            state <= EG_IDLE;
          end else begin
            level <= level - {3'b0, rstep};
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/snd_pcm_fetch.sv
module snd_pcm_fetch
  import snd_voice_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    enable,
  input  logic                    kill,
  input  logic                    advance,
  input  pcm_mode_e               mode,
  input  logic [IDX_W-1:0]        last_idx,
  output logic                    req_valid,
  input  logic                    req_ready,
  output logic [IDX_W-1:0]        req_index,
  input  logic signed [SMP_W-1:0] req_data,
  output logic signed [SMP_W-1:0] sample
);

  logic             pend, done, dir_down;
  logic [IDX_W-1:0] idx, nidx;
  logic             ndir, finish;
  logic             at_end, at_zero, len_one;

  assign at_end  = (idx == last_idx);
  assign at_zero = (idx == '0);
  assign len_one = (last_idx == '0);

  always_comb begin
    nidx   = idx + IDX_W'(1);
    ndir   = dir_down;
    finish = 1'b0;
    case (mode)
      PM_LOOP: if (at_end) nidx = '0;
      PM_PINGPONG: begin
        if (!dir_down) begin
          if (at_end) begin
            nidx = len_one ? '0 : last_idx - IDX_W'(1);
            ndir = 1'b1;
          end
        end else if (at_zero) begin
          nidx = len_one ? '0 : IDX_W'(1);
          ndir = 1'b0;
        end else begin
          nidx = idx - IDX_W'(1);
        end
      end
      default: if (at_end) finish = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0; done <= 1'b0; dir_down <= 1'b0;
      idx <= '0; sample <= '0;
    end else if (kill) begin
      pend <= 1'b0;
      sample <= '0;
    end else if (start) begin
      pend <= enable; done <= 1'b0; dir_down <= 1'b0;
      idx <= '0; sample <= '0;
    end else if (pend) begin
      if (req_ready) begin
        sample <= req_data;
        pend   <= 1'b0;
      end
    end else if (advance && !done) begin
      if (finish) begin
        done   <= 1'b1;
        sample <= '0;
      end else begin
        idx      <= nidx;
        dir_down <= ndir;
        pend     <= 1'b1;
      end
    end
  end

  assign req_valid = pend;
  assign req_index = idx;

endmodule

// File: rtl/snd_voice.sv
module snd_voice
  import snd_voice_pkg::*;
#(
  parameter int PHASE_W = 16,
  parameter int IDX_W   = 8,
  parameter int VOL_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [2:0]         wave_sel,
  input  logic [PHASE_W-1:0] phase_inc,
  input  logic [15:0]        env_word,
  input  logic [VOL_W-1:0]   volume,
  input  logic [1:0]         pcm_mode,
  input  logic [IDX_W-1:0]   pcm_last,
  input  logic               play,
  input  logic               key_off,
  input  logic               stop,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [IDX_W-1:0]   req_index,
  input  logic [15:0]        req_data,
  output logic               out_valid,
  output logic [15:0]        out_sample
);

  localparam int PROD_W = SMP_W + LEVEL_W + VOL_W + 2;
  localparam int SHIFT  = LEVEL_W + VOL_W - 2;
  localparam logic signed [PROD_W-1:0] MAXV = PROD_W'(32767);
  localparam logic signed [PROD_W-1:0] MINV = -MAXV - PROD_W'(1);

  wave_e                    wsel;
  logic                     is_pcm, tick_go;
  logic [15:0]              h;
  logic [NOISE_W-1:0]       noise;
  logic signed [SMP_W-1:0]  pcm_sample, wave;
  logic [LEVEL_W-1:0]       env_level;
  eg_state_e                env_state;
  logic signed [PROD_W-1:0] prod, scaled;
  logic signed [SMP_W-1:0]  sat;

  assign wsel    = wave_e'(wave_sel);
  assign is_pcm  = (wsel == WV_PCM);
  assign tick_go = tick && !stop && !play;

  snd_phase_gen #(.PHASE_W(PHASE_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .restart(play && !stop), .advance(tick_go),
    .inc(phase_inc), .phase_top(h), .noise(noise)
  );

  snd_wave_gen u_wave (
    .sel(wsel), .h(h), .noise(noise), .pcm(pcm_sample), .wave(wave)
  );

  snd_adsr u_env (
    .clk(clk), .rst_n(rst_n), .start(play), .kill(stop), .key_off(key_off),
    .advance(tick_go), .env_word(env_word), .level(env_level), .state(env_state)
  );

  snd_pcm_fetch #(.IDX_W(IDX_W)) u_pcm (
    .clk(clk), .rst_n(rst_n), .start(play), .enable(is_pcm), .kill(stop),
    .advance(tick_go && is_pcm && env_state != EG_IDLE),
    .mode(pcm_mode_e'(pcm_mode)), .last_idx(pcm_last),
    .req_valid(req_valid), .req_ready(req_ready), .req_index(req_index),
    .req_data($signed(req_data)), .sample(pcm_sample)
  );

  assign prod = $signed(PROD_W'(wave)) * $signed(PROD_W'({1'b0, env_level}))
              * $signed(PROD_W'({1'b0, volume}));
  assign scaled = prod >>> SHIFT;

  always_comb begin
    if (scaled > MAXV)      sat = 16'sh7FFF;
    else if (scaled < MINV) sat = 16'sh8000;
    else                    sat = scaled[SMP_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || stop || play) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= tick;
      if (tick) out_sample <= sat;
    end
  end

endmodule

// File: rtl/snd_voice_chk.sv
module snd_voice_chk
  import snd_voice_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick,
  input logic               play,
  input logic               stop,
  input logic               key_off,
  input logic               out_valid,
  input logic [15:0]        out_sample,
  input logic               req_valid,
  input logic               req_ready,
  input logic [IDX_W-1:0]   req_index,
  input logic [LEVEL_W-1:0] env_level,
  input eg_state_e          env_state
);

  AST_TICK_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !stop && !play |=> out_valid); // R2

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> !out_valid); // R2

  AST_STOP_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> out_sample == 16'd0 && env_level == '0 && !req_valid); // R9

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready && !stop && !play |=> req_valid && $stable(req_index)); // R11

  AST_ATTACK_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    env_state == EG_ATTACK && tick && !stop && !play && !key_off
    |=> env_level > $past(env_level)); // R6

  AST_RELEASE_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    env_state == EG_RELEASE && env_level != '0 && tick && !stop && !play
    |=> env_level < $past(env_level)); // R8

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    env_state == EG_IDLE |-> env_level == '0); // R8

endmodule

bind snd_voice snd_voice_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .play(play), .stop(stop),
  .key_off(key_off), .out_valid(out_valid), .out_sample(out_sample),
  .req_valid(req_valid), .req_ready(req_ready), .req_index(req_index),
  .env_level(env_level), .env_state(env_state)
);

// File: tb/snd_voice_bench.sv
`timescale 1ns/1ps
module snd_voice_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, play = 1'b0, key_off = 1'b0, stop = 1'b0;
  logic [2:0]  wave_sel = 3'd0;
  logic [15:0] phase_inc = 16'd0;
  logic [15:0] env_word = 16'hF0F0;
  logic [7:0]  volume = 8'd64;
  logic [1:0]  pcm_mode = 2'd0;
  logic [7:0]  pcm_last = 8'd3;
  logic        req_valid, req_ready = 1'b0;
  logic [7:0]  req_index;
  logic [15:0] req_data = 16'd0;
  logic        out_valid;
  logic [15:0] out_sample;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  snd_voice u_snd_voice (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wave_sel(wave_sel),
    .phase_inc(phase_inc), .env_word(env_word), .volume(volume),
    .pcm_mode(pcm_mode), .pcm_last(pcm_last), .play(play), .key_off(key_off),
    .stop(stop), .req_valid(req_valid), .req_ready(req_ready),
    .req_index(req_index), .req_data(req_data), .out_valid(out_valid),
    .out_sample(out_sample)
  );

  typedef struct packed {
    logic [3:0]         req;
    logic [2:0]         ws;
    logic [15:0]        inc;
    logic [7:0]         vol;
    logic [3:0]         nt;
    logic signed [15:0] exp;
  } vec_t;

  // R3 square/saw/triangle, R4 sine, R5 noise, R10 saturation, R6 first tick
  localparam int NVEC = 13;
  localparam vec_t VECS [NVEC] = '{
    '{4'd3,  3'd0, 16'h1000, 8'd64,  4'd2,  16'sd32639},
    '{4'd3,  3'd0, 16'h9000, 8'd64,  4'd2, -16'sd32640},
    '{4'd3,  3'd1, 16'h4000, 8'd64,  4'd2, -16'sd16320},
    '{4'd3,  3'd2, 16'h2000, 8'd64,  4'd2, -16'sd16320},
    '{4'd3,  3'd2, 16'hC000, 8'd64,  4'd2, -16'sd2},
    '{4'd4,  3'd3, 16'h4000, 8'd64,  4'd2,  16'sd32637},
    '{4'd4,  3'd3, 16'hC000, 8'd64,  4'd2, -16'sd32638},
    '{4'd4,  3'd3, 16'h0400, 8'd64,  4'd2,  16'sd4427},
    '{4'd5,  3'd4, 16'h8000, 8'd64,  4'd2, -16'sd21196},
    '{4'd5,  3'd4, 16'h8000, 8'd64,  4'd3, -16'sd7539},
    '{4'd10, 3'd0, 16'h1000, 8'd255, 4'd2,  16'sd32767},
    '{4'd10, 3'd0, 16'h9000, 8'd255, 4'd2, -16'sd32768},
    '{4'd6,  3'd0, 16'h1000, 8'd64,  4'd1,  16'sd0}
  };

  function automatic int scale(int w, int lvl, int vol);
    longint p;
    p = longint'(w) * longint'(lvl) * longint'(vol);
    p = p >>> 14;
    if (p > 32767) p = 32767;
    if (p < -32768) p = -32768;
    return int'(p);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int outv();
    return int'($signed(out_sample));
  endfunction

  task automatic do_play(input logic [2:0] ws, input logic [15:0] inc,
                         input logic [7:0] vol, input logic [15:0] env,
                         input logic [1:0] mode);
    @(negedge clk);
    wave_sel = ws; phase_inc = inc; volume = vol; env_word = env;
    pcm_mode = mode; play = 1'b1;
    @(negedge clk);
    play = 1'b0;
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic serve(output int idx);
    int n;
    n = 0;
    while (!req_valid && n < 20) begin
      @(negedge clk);
      n++;
    end
    if (req_valid) begin
      idx = int'(req_index);
      req_data = 16'(1000 * (idx + 1));
      req_ready = 1'b1;
      @(negedge clk);
      req_ready = 1'b0;
    end else begin
      idx = -1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int got;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 out_sample", outv(), 0);
    check("R1 out_valid", int'(out_valid), 0);
    check("R1 req_valid", int'(req_valid), 0);
    rst_n = 1'b1;

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      do_play(VECS[v].ws, VECS[v].inc, VECS[v].vol, 16'hF0F0, 2'd0);
      for (int t = 0; t < int'(VECS[v].nt); t++) do_tick();
      check($sformatf("R%0d vec%0d", VECS[v].req, v), outv(), int'(VECS[v].exp));
      check("R2 out_valid after tick", int'(out_valid), 1);
    end
    @(negedge clk);
    check("R2 out_valid idle", int'(out_valid), 0);

    // R6 R7 R8 envelope walk, square with zero increment
    do_play(3'd0, 16'h0000, 8'd64, 16'h378F, 2'd0);
    do_tick(); check("R6 attack t1", outv(), 0);
    do_tick(); check("R6 attack t2", outv(), scale(32767, 64, 64));
    do_tick(); check("R6 attack t3", outv(), scale(32767, 128, 64));
    do_tick(); do_tick();
    check("R6 attack clamp", outv(), scale(32767, 255, 64));
    for (int t = 0; t < 30; t++) do_tick();
    check("R7 sustain", outv(), scale(32767, 136, 64));
    @(negedge clk); key_off = 1'b1;
    @(negedge clk); key_off = 1'b0;
    do_tick(); check("R8 release t1", outv(), scale(32767, 136, 64));
    do_tick(); check("R8 release t2", outv(), scale(32767, 120, 64));
    for (int t = 0; t < 10; t++) do_tick();
    check("R8 release end", outv(), 0);

    // R9 stop coinciding with a tick
    do_play(3'd0, 16'h0000, 8'd64, 16'hF0F0, 2'd0);
    do_tick(); do_tick(); do_tick();
    check("R9 before stop", outv(), scale(32767, 255, 64));
    @(negedge clk); stop = 1'b1; tick = 1'b1;
    @(negedge clk); stop = 1'b0; tick = 1'b0;
    check("R9 stop sample", outv(), 0);
    check("R9 stop no valid", int'(out_valid), 0);
    do_tick(); check("R9 silent after stop", outv(), 0);

    // R12 once mode
    pcm_last = 8'd3;
    do_play(3'd5, 16'h0000, 8'd64, 16'hF0F0, 2'd0);
    serve(got); check("R11 first index", got, 0);
    do_tick(); serve(got); check("R12 once idx1", got, 1);
    do_tick(); check("R12 custom sample", outv(), scale(2000, 255, 64));
    serve(got); check("R12 once idx2", got, 2);
    do_tick(); serve(got); check("R12 once idx3", got, 3);
    do_tick(); check("R12 no request at end", int'(req_valid), 0);
    do_tick(); check("R12 silent at end", outv(), 0);

    // R13 loop mode with R11 back-pressure
    do_play(3'd5, 16'h0000, 8'd64, 16'hF0F0, 2'd1);
    serve(got); check("R13 loop idx0", got, 0);
    do_tick(); serve(got); check("R13 loop idx1", got, 1);
    do_tick();
    check("R11 held valid", int'(req_valid), 1);
    check("R11 held index", int'(req_index), 2);
    do_tick();
    check("R11 tick while open", int'(req_index), 2);
    serve(got); check("R11 resume", got, 2);
    do_tick(); serve(got); check("R13 loop idx3", got, 3);
    do_tick(); serve(got); check("R13 loop wrap", got, 0);
    do_tick(); serve(got); check("R13 loop idx1b", got, 1);

    // R14 ping-pong mode
    begin
      int pp [7] = '{1, 2, 3, 2, 1, 0, 1};
      do_play(3'd5, 16'h0000, 8'd64, 16'hF0F0, 2'd2);
      serve(got); check("R14 pp idx0", got, 0);
      for (int k = 0; k < 7; k++) begin
        do_tick(); serve(got);
        check($sformatf("R14 pp step%0d", k), got, pp[k]);
      end
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule